// File: doc/BRIEF.md
# In-Band Loop Code Detector

This block watches a received serial bit stream, one bit per valid strobe, for two repeating in-band codes. The activate code repeats `00001`, one 1 in every five bits. The release code repeats `001`, one 1 in every three bits. A 2-bit mode input selects one of three behaviours: detection off, manual qualification of a single code, or automatic control of a remote loopback. Line decoding, framing and the loopback datapath sit outside the block. It only drives two flags, `code_det` and `rmt_lpbk`.

A code is tracked at any bit phase. It must stay present without a break for `THRESH_BITS` consecutive bit periods before it counts. The default is five seconds of bits at 1.544 Mb/s, and a bench can make it much shorter. In manual mode the detect flag follows the qualified state of the selected code. In automatic mode the block runs a latched two-phase sequence. A qualified activate code raises both outputs together. The outputs then stay high, whether the activate code is present or not, until a qualified release code clears them.

Top module: `loopcode_detector`

## Requirements
- R1: A code is "in step" after a bit when the last P received bits contain exactly one 1. P is 5 for the activate code and 3 for the release code. At least P bits must have been received since the last clear. The phase of the 1 within the period does not matter.
- R2: `mode` encoding: 2'b00 turns detection off and holds both outputs low. 2'b01 is manual mode for the activate code. 2'b10 is manual mode for the release code. 2'b11 is automatic mode.
- R3: A code qualifies once it has been in step for `THRESH_BITS` consecutive received bits. One out-of-step bit restarts the count. The count saturates and never wraps, so a run of any length stays qualified.
- R4: In manual mode, `code_det` equals the qualified state of the selected code. It rises once the code qualifies and falls after the first out-of-step bit. Each output change lands two clock edges after the strobe edge that caused it.
- R5: In automatic mode, while loopback is inactive, a qualified activate code raises `code_det` and `rmt_lpbk` on the same edge.
- R6: While automatic loopback is active, both outputs stay high whether the activate code continues, stops or changes.
- R7: While automatic loopback is active, a qualified release code clears both outputs together. The block then searches for the activate code again.
- R8: A change of `mode` clears both outputs on the next edge. It also discards all bit history and duration counts, so qualification starts again from zero.
- R9: A synchronous `rst` drives both outputs low and clears all history.
- R10: `rmt_lpbk` is never high outside automatic mode, and it is never high while `code_det` is low.
- R11: Cycles with `bit_vld` low are ignored whatever `rx_bit` carries. They neither advance nor break qualification.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | High in cycles that carry a received bit |
| rx_bit | input | 1 | Received data bit, valid when `bit_vld` is high |
| mode | input | 2 | Detection mode (R2) |
| code_det | output | 1 | Registered loop code detect flag |
| rmt_lpbk | output | 1 | Registered remote loopback enable |

## Verification
The bench builds the block with `THRESH_BITS` = 20 in place of millions. This shortens a qualification to 24 activate bits or 22 release bits. The exact one-bit-short and one-bit-over boundaries, saturation over runs three times the threshold, and a full automatic set/hold/clear/re-arm cycle then all fit in a few thousand clocks. The behavioural queue model checks every clock, including the two-edge output latency.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  localparam int UP_LEN = 5;
  localparam int DN_LEN = 3;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_MAN_UP = 2'b01,
    MODE_MAN_DN = 2'b10,
    MODE_AUTO   = 2'b11
  } lcd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MANUAL,
    ST_ARM_WAIT,
    ST_LOOPED
  } lcd_state_e;

  function automatic lcd_state_e entry_state(lcd_mode_e m);
    case (m)
      MODE_OFF:  return ST_IDLE;
      MODE_AUTO: return ST_ARM_WAIT;
      default:   return ST_MANUAL;
    endcase
  endfunction

endpackage

// File: rtl/lcd_pattern_trk.sv
module lcd_pattern_trk #(
  parameter int PERIOD = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_vld,
  input  logic rx_bit,
  output logic tick,
  output logic good
);

  localparam int FW = $clog2(PERIOD + 1);

  logic [PERIOD-1:0] win;
  logic [FW-1:0]     fill;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win  <= '0;
      fill <= '0;
      tick <= 1'b0;
    end else begin
      tick <= bit_vld;
      if (bit_vld) begin
        win <= {win[PERIOD-2:0], rx_bit};
        if (fill != FW'(PERIOD)) fill <= fill + 1'b1;
      end
    end
  end

  // A window with one 1 stays one-hot only if each new bit repeats the bit
  // shifted out, so this is exact periodicity at any phase.
  assign good = (fill == FW'(PERIOD)) && ($countones(win) == 1);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(PERIOD)); // R1

  AST_SLIP_BREAKS: assert property (@(posedge clk) disable iff (rst)
    (good && bit_vld && !clr && (rx_bit != win[PERIOD-1])) |=> !good); // R1

endmodule

// File: rtl/lcd_dur_cnt.sv
module lcd_dur_cnt #(
  parameter int THRESH = 7720000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  input  logic good,
  output logic qual
);

  localparam int CW = $clog2(THRESH + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (tick) begin
      if (!good)                   cnt <= '0;
      else if (cnt != CW'(THRESH)) cnt <= cnt + 1'b1;
    end
  end

  assign qual = (cnt == CW'(THRESH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(THRESH)); // R3

  AST_SLIP_RESTART: assert property (@(posedge clk) disable iff (rst)
    (tick && !good) |=> (cnt == '0)); // R3

  AST_QUAL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (qual && !clr && !(tick && !good)) |=> qual); // R3

endmodule

// File: rtl/lcd_ctrl_fsm.sv
module lcd_ctrl_fsm
  import lcd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  lcd_mode_e mode,
  input  logic      qual_up,
  input  logic      qual_dn,
  output logic      mode_chg,
  output logic      code_det,
  output logic      rmt_lpbk
);

  lcd_mode_e  mode_q;
  lcd_state_e st;

  assign mode_chg = (mode != mode_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_OFF;
      st       <= ST_IDLE;
      code_det <= 1'b0;
      rmt_lpbk <= 1'b0;
    end else begin
      mode_q <= mode;
      if (mode_chg) begin
        st       <= entry_state(mode);
        code_det <= 1'b0;
        rmt_lpbk <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: begin
            code_det <= 1'b0;
            rmt_lpbk <= 1'b0;
          end
          ST_MANUAL: begin
            code_det <= (mode_q == MODE_MAN_UP) ? qual_up : qual_dn;
            rmt_lpbk <= 1'b0;
          end
          ST_ARM_WAIT: begin
            if (qual_up) begin
              st       <= ST_LOOPED;
              code_det <= 1'b1;
              rmt_lpbk <= 1'b1;
            end
          end
          ST_LOOPED: begin
            if (qual_dn) begin
              st       <= ST_ARM_WAIT;
              code_det <= 1'b0;
              rmt_lpbk <= 1'b0;
            end
          end
          default: begin
            st       <= ST_IDLE;
            code_det <= 1'b0;
            rmt_lpbk <= 1'b0;
          end
        endcase
      end
    end
  end

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_OFF) |-> (!code_det && !rmt_lpbk)); // R2

  AST_AUTO_SET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ARM_WAIT && qual_up && !mode_chg) |=> (code_det && rmt_lpbk)); // R5

  AST_AUTO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOPED && !qual_dn && !mode_chg) |=> (code_det && rmt_lpbk)); // R6

  AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LOOPED && qual_dn && !mode_chg) |=> (!code_det && !rmt_lpbk)); // R7

  AST_MODE_CHG_CLR: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> (!code_det && !rmt_lpbk)); // R8

  AST_LPBK_NEEDS_DET: assert property (@(posedge clk) disable iff (rst)
    rmt_lpbk |-> code_det); // R10

  AST_LPBK_AUTO_ONLY: assert property (@(posedge clk) disable iff (rst)
    rmt_lpbk |-> (mode_q == MODE_AUTO)); // R10

endmodule

// File: rtl/loopcode_detector.sv
module loopcode_detector
  import lcd_pkg::*;
#(
  parameter int THRESH_BITS = 7720000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld,
  input  logic       rx_bit,
  input  logic [1:0] mode,
  output logic       code_det,
  output logic       rmt_lpbk
);

  localparam int NCODE = 2;

  logic             clr;
  logic [NCODE-1:0] tick;
  logic [NCODE-1:0] good;
  logic [NCODE-1:0] qual;

  // index 0 tracks the activate code, index 1 the release code
  for (genvar g = 0; g < NCODE; g++) begin : g_code
    localparam int P = (g == 0) ? UP_LEN : DN_LEN;

    lcd_pattern_trk #(.PERIOD(P)) i_trk (
      .clk     (clk),
      .rst     (rst),
      .clr     (clr),
      .bit_vld (bit_vld),
      .rx_bit  (rx_bit),
      .tick    (tick[g]),
      .good    (good[g])
    );

    lcd_dur_cnt #(.THRESH(THRESH_BITS)) i_cnt (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .tick (tick[g]),
      .good (good[g]),
      .qual (qual[g])
    );
  end

  lcd_ctrl_fsm i_fsm (
    .clk      (clk),
    .rst      (rst),
    .mode     (lcd_mode_e'(mode)),
    .qual_up  (qual[0]),
    .qual_dn  (qual[1]),
    .mode_chg (clr),
    .code_det (code_det),
    .rmt_lpbk (rmt_lpbk)
  );

endmodule

// File: tb/test_loopcode_detector.sv
`timescale 1ns/1ps
module test_loopcode_detector;

  localparam int TH = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_vld = 1'b0;
  logic       rx_bit = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       code_det, rmt_lpbk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  loopcode_detector #(.THRESH_BITS(TH)) i_loopcode_detector (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .rx_bit(rx_bit), .mode(mode),
    .code_det(code_det), .rmt_lpbk(rmt_lpbk)
  );

  // ---------------- behavioural reference model ----------------
  int   q_up[$];
  int   q_dn[$];
  bit   m_tick;
  int   m_cu, m_cd;
  bit   m_det, m_lb, m_looped;
  logic [1:0] m_prev;

  function automatic bit win_ok(int q[$], int p);
    int s = 0;
    if (q.size() != p) return 1'b0;
    foreach (q[k]) s += q[k];
    return s == 1;
  endfunction

  always @(posedge clk) begin : model
    bit chg, qu, qd, gu, gd;
    if (rst) begin
      q_up.delete(); q_dn.delete();
      m_tick = 0; m_cu = 0; m_cd = 0;
      m_det = 0; m_lb = 0; m_looped = 0; m_prev = 2'b00;
    end else begin
      chg = (mode != m_prev);
      qu = (m_cu >= TH);
      qd = (m_cd >= TH);
      gu = win_ok(q_up, 5);
      gd = win_ok(q_dn, 3);
      if (chg) begin
        m_det = 0; m_lb = 0; m_looped = 0;
      end else begin
        case (mode)
          2'b00: begin m_det = 0; m_lb = 0; end
          2'b01: begin m_det = qu; m_lb = 0; end
          2'b10: begin m_det = qd; m_lb = 0; end
          default: begin
            if (!m_looped && qu) begin m_looped = 1; m_det = 1; m_lb = 1; end
            else if (m_looped && qd) begin m_looped = 0; m_det = 0; m_lb = 0; end
          end
        endcase
      end
      if (chg) begin
        m_cu = 0; m_cd = 0;
      end else if (m_tick) begin
        m_cu = gu ? ((m_cu < TH) ? m_cu + 1 : m_cu) : 0;
        m_cd = gd ? ((m_cd < TH) ? m_cd + 1 : m_cd) : 0;
      end
      if (chg) begin
        q_up.delete(); q_dn.delete(); m_tick = 0;
      end else begin
        m_tick = bit_vld;
        if (bit_vld) begin
          q_up.push_back(int'(rx_bit)); if (q_up.size() > 5) void'(q_up.pop_front());
          q_dn.push_back(int'(rx_bit)); if (q_dn.size() > 3) void'(q_dn.pop_front());
        end
      end
      m_prev = mode;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      n_chk++;
      if (code_det !== m_det || rmt_lpbk !== m_lb) begin
        n_fail++;
        $display("FAIL R4 model compare at %0t: actual det=%0b lb=%0b expected det=%0b lb=%0b",
                 $time, code_det, rmt_lpbk, m_det, m_lb);
      end
    end
  end

  // ---------------- checks and stimulus ----------------
  task automatic chk(input string tag, input bit exp_det, input bit exp_lb);
    n_chk++;
    if (code_det !== exp_det || rmt_lpbk !== exp_lb) begin
      n_fail++;
      $display("FAIL %s: actual det=%0b lb=%0b expected det=%0b lb=%0b",
               tag, code_det, rmt_lpbk, exp_det, exp_lb);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_vld = 0; rx_bit = 0;
    end
  endtask

  // per = code length, ph = starting index in the pattern, n = bits
  task automatic send(input int per, input int ph, input int n, input bit stall);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_vld = 1; rx_bit = (((i + ph) % per) == per - 1);
      if (stall && (i % 3) == 1) begin
        @(negedge clk); bit_vld = 0; rx_bit = ~rx_bit;
      end
    end
    idle(4);
  endtask

  task automatic send_const(input bit v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_vld = 1; rx_bit = v;
    end
    idle(4);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode = m;
    idle(3);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    chk("R9 after reset", 0, 0);

    // off mode ignores codes
    send(5, 0, 40, 0);
    chk("R2 mode off holds low", 0, 0);

    // manual activate code: one short, then exact
    set_mode(2'b01);
    send(5, 0, 23, 0);
    chk("R3 one bit short of threshold", 0, 0);
    send(5, 23, 1, 0);
    chk("R4 manual rises at threshold", 1, 0);
    send_const(0, 1);
    chk("R4 manual falls on slip", 0, 0);

    // other phase
    set_mode(2'b00); set_mode(2'b01);
    send(5, 2, 23, 0);
    chk("R1 shifted phase short", 0, 0);
    send(5, 25, 1, 0);
    chk("R1 shifted phase qualifies", 1, 0);

    // restart after a stray 1
    set_mode(2'b00); set_mode(2'b01);
    send(5, 0, 15, 0);
    send_const(1, 1);
    send(5, 16, 23, 0);
    chk("R3 restart after slip short", 0, 0);
    send(5, 39, 1, 0);
    chk("R3 restart then qualifies", 1, 0);

    // saturation over a long run
    send(5, 40, 60, 0);
    chk("R3 saturated long run", 1, 0);
    send_const(1, 1);
    chk("R3 slip after saturation", 0, 0);

    // gaps in the strobe
    set_mode(2'b00); set_mode(2'b01);
    send(5, 0, 23, 1);
    chk("R11 stalled stream short", 0, 0);
    send(5, 23, 1, 0);
    chk("R11 stalled stream qualifies", 1, 0);

    // manual release code
    set_mode(2'b00); set_mode(2'b10);
    send(5, 0, 40, 0);
    chk("R2 release mode ignores activate code", 0, 0);
    set_mode(2'b00); set_mode(2'b10);
    send(3, 0, 21, 0);
    chk("R2 release code short", 0, 0);
    send(3, 21, 1, 0);
    chk("R2 release code qualifies", 1, 0);

    // automatic sequence
    set_mode(2'b00); set_mode(2'b11);
    send(5, 0, 23, 0);
    chk("R5 auto short", 0, 0);
    send(5, 23, 1, 0);
    chk("R5 auto sets both", 1, 1);
    send_const(0, 40);
    chk("R6 hold without code", 1, 1);
    send(5, 0, 30, 0);
    chk("R6 hold with code again", 1, 1);
    send_const(0, 5);
    send(3, 0, 21, 0);
    chk("R7 release short", 1, 1);
    send(3, 21, 1, 0);
    chk("R7 release clears both", 0, 0);
    send_const(0, 5);
    send(5, 0, 23, 0);
    chk("R7 re-arm short", 0, 0);
    send(5, 23, 1, 0);
    chk("R7 re-arm sets again", 1, 1);

    // mode change
    set_mode(2'b01);
    chk("R8 mode change clears", 0, 0);
    send(5, 0, 24, 0);
    chk("R10 manual never loops back", 1, 0);

    // reset mid-run
    @(negedge clk); rst = 1;
    idle(2);
    chk("R9 reset clears", 0, 0);
    @(negedge clk); rst = 0;
    idle(3);
    chk("R9 after release of reset", 0, 0);

    finish_run();
  end

endmodule